// File: doc/BRIEF.md
# Backlight PWM Generator with Commit-Latched Settings

This block produces one pulse-width-modulated output for dimming a display backlight. A shared prescaler stretches each step of the waveform. A period counter then sets the frame length, and a high-width compare sets how long the pin stays high in each frame. Software programs the prescaler divisor, the period and the high width through a small synchronous register port. The port has a word address, write data, a write strobe and combinational read data.

The three waveform settings are first written into a staging set, which has no effect on the pin. A 0-to-1 transition of the commit bit arms a copy of the staging set into the active set. If the generator is running, the copy waits for the end of the current frame, so no frame is ever cut short or mixed. If the generator is stopped, the copy happens on the next clock. The enable bit is not staged and acts at once.

Top module: `bl_pwm`

## Requirements
- R1: After a synchronous active-high reset, every register reads zero and the output is low.
- R2: The register map uses word addresses. Address 0 holds enable in bit 0, and address 2 holds commit in bit 0. Address 4 holds the 10-bit divisor in bits 25:16. Address 5 holds the 12-bit period in bits 11:0 and the 13-bit high width in bits 28:16. Reads return the staged values with all other bits zero. Any other address reads zero and ignores writes.
- R3: A write to the divisor, period or high width does not change the waveform until a commit follows.
- R4: While enabled, a commit takes effect at the next frame boundary. The frame in progress completes with the old settings.
- R5: While disabled, a commit loads the active set one clock after the commit write.
- R6: One frame lasts (divisor+1)×(period+1) clock cycles. The output is high for the first (divisor+1)×high_width of those cycles.
- R7: A high width of 0 gives a constant low output. A high width of period+1 or more gives a constant high output.
- R8: While disabled, the output is low and the counters are held at zero. Enabling starts a fresh frame that begins high when the high width is nonzero.
- R9: Only a 0-to-1 change of the commit bit arms a transfer. Writing 1 while the bit already reads 1 arms nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr_i | input | 4 | Word address |
| bus_wdata_i | input | 32 | Write data |
| bus_we_i | input | 1 | Write strobe |
| bus_rdata_o | output | 32 | Read data for bus_addr_i |
| pwm_o | output | 1 | PWM output |

## Verification
A table of settings is applied through commit-while-stopped, and one or two frames are counted for each. The rows separate the divisor scaling from the period length, and a zero divisor from a nonzero one. They also include the two saturating high widths, zero and beyond the period. Directed sequences then stage new values mid-frame, first without a commit and then with one, which tells deferred loading apart from immediate loading. Further sequences repeat a commit while the bit is already set, and stop the generator mid-frame to confirm the counters restart.

// File: rtl/bl_pwm.sv
module bl_pwm #(
  parameter int DIV_W  = 10,
  parameter int PER_W  = 12,
  parameter int HW_W   = 13,
  parameter int ADDR_W = 4,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] bus_addr_i,
  input  logic [DATA_W-1:0] bus_wdata_i,
  input  logic              bus_we_i,
  output logic [DATA_W-1:0] bus_rdata_o,
  output logic              pwm_o
);
  localparam logic [ADDR_W-1:0] A_EN  = ADDR_W'(0);
  localparam logic [ADDR_W-1:0] A_CMT = ADDR_W'(2);
  localparam logic [ADDR_W-1:0] A_DIV = ADDR_W'(4);
  localparam logic [ADDR_W-1:0] A_WAV = ADDR_W'(5);
  localparam int DIV_LSB = 16;
  localparam int HW_LSB  = 16;
  localparam int CW = ((PER_W > HW_W) ? PER_W : HW_W) + 1;

  logic             en_q, cmt_q, pend_q;
  logic [DIV_W-1:0] stg_div, act_div, pre_cnt;
  logic [PER_W-1:0] stg_per, act_per, per_cnt;
  logic [HW_W-1:0]  stg_hw, act_hw;

  wire sel_en  = bus_we_i && (bus_addr_i == A_EN);
  wire sel_cmt = bus_we_i && (bus_addr_i == A_CMT);
  wire sel_div = bus_we_i && (bus_addr_i == A_DIV);
  wire sel_wav = bus_we_i && (bus_addr_i == A_WAV);

  wire cmt_rise = sel_cmt && bus_wdata_i[0] && !cmt_q;
  wire pre_last = (pre_cnt == act_div);
  wire per_last = (per_cnt == act_per);
  wire boundary = en_q && pre_last && per_last;
  wire load     = pend_q && (!en_q || boundary);

  always_ff @(posedge clk) begin
    if (rst) begin
      en_q    <= 1'b0;
      cmt_q   <= 1'b0;
      pend_q  <= 1'b0;
      stg_div <= '0;
      stg_per <= '0;
      stg_hw  <= '0;
      act_div <= '0;
      act_per <= '0;
      act_hw  <= '0;
    end else begin
      if (sel_en)  en_q  <= bus_wdata_i[0];
      if (sel_cmt) cmt_q <= bus_wdata_i[0];
      if (sel_div) stg_div <= bus_wdata_i[DIV_LSB +: DIV_W];
      if (sel_wav) begin
        stg_per <= bus_wdata_i[PER_W-1:0];
        stg_hw  <= bus_wdata_i[HW_LSB +: HW_W];
      end
      if (load) begin
        act_div <= stg_div;
        act_per <= stg_per;
        act_hw  <= stg_hw;
      end
      if (cmt_rise)  pend_q <= 1'b1;
      else if (load) pend_q <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst || !en_q) begin
      pre_cnt <= '0;
      per_cnt <= '0;
    end else if (pre_last) begin
      pre_cnt <= '0;
      per_cnt <= per_last ? '0 : per_cnt + 1'b1;
    end else begin
      pre_cnt <= pre_cnt + 1'b1;
    end
  end

  assign pwm_o = en_q && (CW'(per_cnt) < CW'(act_hw));

  always_comb begin
    bus_rdata_o = '0;
    case (bus_addr_i)
      A_EN:  bus_rdata_o[0] = en_q;
      A_CMT: bus_rdata_o[0] = cmt_q;
      A_DIV: bus_rdata_o[DIV_LSB +: DIV_W] = stg_div;
      A_WAV: begin
        bus_rdata_o[PER_W-1:0]       = stg_per;
        bus_rdata_o[HW_LSB +: HW_W] = stg_hw;
      end
      default: bus_rdata_o = '0;
    endcase
  end

  // R8
  idle_cnt_zero_chk: assert property (@(posedge clk) disable iff (rst)
    !en_q |=> (pre_cnt == '0 && per_cnt == '0));

  // R6
  cnt_in_range_chk: assert property (@(posedge clk) disable iff (rst)
    (pre_cnt <= act_div) && (per_cnt <= act_per));

  // R4
  act_change_armed_chk: assert property (@(posedge clk) disable iff (rst)
    ((act_hw != $past(act_hw)) || (act_per != $past(act_per)) ||
     (act_div != $past(act_div))) |-> $past(pend_q));

  // R4
  rise_at_frame_start_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(pwm_o) |-> (pre_cnt == '0 && per_cnt == '0));
endmodule

// File: tb/bl_pwm_tb.sv
module bl_pwm_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int NV = 6;
  localparam int V_DIV [NV] = '{0, 2, 1, 0, 3, 0};
  localparam int V_PER [NV] = '{3, 4, 5, 2, 1, 0};
  localparam int V_HW  [NV] = '{2, 3, 0, 7, 2, 1};

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [3:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic        bus_we = 1'b0;
  logic [31:0] bus_rdata;
  logic        pwm;
  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  bl_pwm dut_i (
    .clk(clk), .rst(rst), .bus_addr_i(bus_addr), .bus_wdata_i(bus_wdata),
    .bus_we_i(bus_we), .bus_rdata_o(bus_rdata), .pwm_o(pwm)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic wr(input int a, input int d);
    bus_addr = 4'(a); bus_wdata = 32'(d); bus_we = 1'b1;
    @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic rd(input string req, input int a, input int exp);
    bus_addr = 4'(a);
    #1;
    chk(req, int'(bus_rdata), exp);
  endtask

  task automatic meas(input int n, output int hi);
    hi = 0;
    for (int i = 0; i < n; i++) begin
      if (pwm) hi++;
      @(negedge clk);
    end
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    int h;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    rd("R1", 0, 0); rd("R1", 2, 0); rd("R1", 4, 0); rd("R1", 5, 0);
    chk("R1", int'(pwm), 0);

    // R2 field masking and unmapped addresses
    wr(4, 32'hFFFF_FFFF); rd("R2", 4, 32'h03FF_0000);
    wr(5, 32'hFFFF_FFFF); rd("R2", 5, 32'h1FFF_0FFF);
    wr(1, 32'hFFFF_FFFF); rd("R2", 1, 0);
    rd("R2", 0, 0);

    // R6/R7/R5 table walk: commit while disabled, then count frames
    for (int v = 0; v < NV; v++) begin
      int p, eh, cap;
      p   = (V_DIV[v] + 1) * (V_PER[v] + 1);
      cap = (V_HW[v] < V_PER[v] + 1) ? V_HW[v] : V_PER[v] + 1;
      eh  = (V_DIV[v] + 1) * cap;
      wr(0, 0);
      wr(4, V_DIV[v] << 16);
      wr(5, (V_HW[v] << 16) | V_PER[v]);
      wr(2, 1);
      wr(2, 0);
      wr(0, 1);
      chk("R8 start level", int'(pwm), (V_HW[v] > 0) ? 1 : 0);
      meas(p, h);
      chk((cap == 0 || cap == V_PER[v] + 1) ? "R7" : "R6", h, eh);
      meas(p, h);
      chk("R6 second frame", h, eh);
    end

    // R8 disable mid-frame then re-enable
    wr(0, 0); wr(4, 1 << 16); wr(5, (2 << 16) | 3); wr(2, 1); wr(2, 0);
    wr(0, 1);
    meas(3, h); chk("R8 before stop", h, 3);
    wr(0, 0);
    meas(3, h); chk("R8 stopped low", h, 0);
    wr(0, 1);
    meas(8, h); chk("R8 restart frame", h, 4);

    // R9 repeated commit while bit set arms nothing
    wr(0, 0); wr(4, 0); wr(5, (1 << 16) | 3); wr(2, 1);
    wr(5, (3 << 16) | 3);
    wr(2, 1);
    wr(0, 1);
    meas(4, h); chk("R9", h, 1);
    rd("R2 staged readback", 5, (3 << 16) | 3);
    // R5 fresh rise while disabled loads at once
    wr(0, 0); wr(2, 0); wr(2, 1); wr(0, 1);
    meas(4, h); chk("R5", h, 3);

    // R3/R4 staging while running
    wr(0, 0); wr(5, (2 << 16) | 7); wr(2, 0); wr(2, 1); wr(2, 0);
    wr(0, 1);
    wr(5, (6 << 16) | 7);
    meas(7, h); chk("R3 rest of frame", h, 1);
    meas(8, h); chk("R3 no commit", h, 2);
    wr(2, 1); wr(2, 0);
    meas(6, h); chk("R4 old frame kept", h, 0);
    meas(8, h); chk("R4 new frame", h, 6);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule